// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small logic array that software or a boot sequence can configure in the field. It has two planes. In the first plane, each product term is the AND of any chosen set of input literals. Every input offers a literal in true form and a literal in complement form. In the second plane, each output is the OR of any chosen set of product terms. Because the OR plane can also be configured, one product term may feed several outputs at once. The number of product terms is usually far below the number of minterms, so a function has to be written as a reduced sum of products.

The configuration arrives one bit per clock on a serial chain while a shift enable is high. It takes effect only when a load strobe copies the whole chain into the active configuration register. Shifting therefore never exposes a half-written pattern. Between the active configuration and the output register the path is purely combinational. The outputs are registered, which gives a single clock of latency from the input vector to the result.

Top module: `pla_array`

## Requirements
- R1: A synchronous reset clears both the chain and the active configuration. While reset is held, and in every cycle after reset until the first load, every output reads 0 for every input vector.
- R2: While cfg_shift is high, each rising clock edge shifts cfg_bit into the chain, most significant bit first. Shifting has no effect on the outputs until a load.
- R3: A load (cfg_load high at a rising clock edge) copies the chain into the active configuration at that edge. Outputs computed from the next input sample use the new configuration.
- R4: The configuration vector has width 2·N_IN·N_TERM + N_OUT·N_TERM. For product term t, bit t·2·N_IN + 2i connects the true form of input i, and bit t·2·N_IN + 2i + 1 connects its complement. A term is the AND of its connected literals.
- R5: A product term with no literal connected evaluates to 1.
- R6: A product term that connects both the true and the complement form of the same input evaluates to 0.
- R7: Output o is the OR of every term t whose bit N_TERM·2·N_IN + o·N_TERM + t is set. One term may feed several outputs.
- R8: An output with no product term connected evaluates to 0.
- R9: out_vec is registered. It shows the function of in_vec as sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, most significant bit first |
| cfg_load | input | 1 | Copies the chain into the active configuration |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Registered sum-of-products outputs |

## Verification
Each output sample is due one clock after the input vector it depends on. A load changes the result starting with the input sample taken at the edge after the strobe. The bench drives inputs on falling edges and keeps a behavioural model that it updates on rising edges. It compares out_vec with the model on every falling edge, so each comparison lands exactly when the registered result is due. Directed configurations cover empty terms, contradictory terms, shared terms and empty outputs. Random configurations are then checked against all 2^N_IN input vectors.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Width of the AND-plane section of the configuration vector
  function automatic int and_bits(input int n_in, input int n_term);
    return 2 * n_in * n_term;
  endfunction

  // Full configuration vector width
  function automatic int cfg_bits(input int n_in, input int n_term, input int n_out);
    return 2 * n_in * n_term + n_out * n_term;
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      active <= '0;
    end else begin
      if (shift_en) chain <= {chain[W-2:0], shift_bit};
      if (load) active <= chain;
    end
  end

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> active == $past(chain));

  // R2
  hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_IN-1:0]            in_vec,
  input  logic [2*N_IN*N_TERM-1:0]   mask,
  output logic [N_TERM-1:0]          term
);
  localparam int LW = 2 * N_IN;

  logic [LW-1:0] lit;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lit[2*i]   = in_vec[i];
      lit[2*i+1] = ~in_vec[i];
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LW-1:0]   sel;
    logic [N_IN-1:0] pair;
    assign sel     = mask[t*LW +: LW];
    assign term[t] = &(lit | ~sel);

    for (genvar i = 0; i < N_IN; i++) begin : g_pair
      assign pair[i] = sel[2*i] & sel[2*i+1];
    end

    // R6
    contra_term_chk: assert property (@(posedge clk) disable iff (rst)
      (|pair) |-> !term[t]);

    // R5
    empty_term_chk: assert property (@(posedge clk) disable iff (rst)
      (sel == '0) |-> term[t]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_TERM-1:0]        term,
  input  logic [N_OUT*N_TERM-1:0]  mask,
  output logic [N_OUT-1:0]         sum
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel;
    assign sel    = mask[o*N_TERM +: N_TERM];
    assign sum[o] = |(term & sel);

    // R8
    empty_out_chk: assert property (@(posedge clk) disable iff (rst)
      (sel == '0) |-> !sum[o]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift,
  input  logic             cfg_bit,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);
  localparam int AW = and_bits(N_IN, N_TERM);
  localparam int CW = cfg_bits(N_IN, N_TERM, N_OUT);

  logic [CW-1:0]     cfg;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sum;

  pla_cfg_chain #(.W(CW)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_shift), .shift_bit(cfg_bit),
    .load(cfg_load), .active(cfg)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst(rst), .in_vec(in_vec), .mask(cfg[AW-1:0]), .term(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst(rst), .term(term), .mask(cfg[CW-1:AW]), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) out_vec <= '0;
    else     out_vec <= sum;
  end

  // R1
  reset_out_chk: assert property (@(posedge clk) rst |=> out_vec == '0);
endmodule

// File: tb/tb_pla_array.sv
module tb_pla_array;
  localparam int N = 4, T = 6, O = 3;
  localparam int AW = 2 * N * T;
  localparam int CW = AW + O * T;

  logic clk = 0, rst = 1, cfg_shift = 0, cfg_bit = 0, cfg_load = 0;
  logic [N-1:0] in_vec = '0;
  logic [O-1:0] out_vec;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [CW-1:0] m_chain, m_act;
  logic [O-1:0]  m_out;

  always #10 clk = ~clk;

  pla_array #(.N_IN(N), .N_TERM(T), .N_OUT(O)) dut (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .cfg_load(cfg_load), .in_vec(in_vec), .out_vec(out_vec)
  );

  function automatic logic [O-1:0] eval(input logic [CW-1:0] c, input logic [N-1:0] x);
    logic [T-1:0] tv;
    logic [O-1:0] r;
    for (int t = 0; t < T; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (c[t*2*N + 2*i] && !x[i]) tv[t] = 1'b0;
        if (c[t*2*N + 2*i + 1] && x[i]) tv[t] = 1'b0;
      end
    end
    for (int o = 0; o < O; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < T; t++)
        if (c[AW + o*T + t] && tv[t]) r[o] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_chain <= '0; m_act <= '0; m_out <= '0;
    end else begin
      m_out <= eval(m_act, in_vec);
      if (cfg_shift) m_chain <= {m_chain[CW-2:0], cfg_bit};
      if (cfg_load) m_act <= m_chain;
    end
  end

  task automatic step();
    @(negedge clk);
    checks++;
    if (out_vec !== m_out) begin
      failures++;
      $display("FAIL %s: out_vec=%b expected=%b (in=%b)", cur_req, out_vec, m_out, in_vec);
    end
  endtask

  task automatic load_cfg(input logic [CW-1:0] c);
    for (int b = CW - 1; b >= 0; b--) begin
      step();
      cfg_shift = 1; cfg_bit = c[b];
      in_vec = N'($urandom);
    end
    step();
    cfg_shift = 0; cfg_load = 1;
    step();
    cfg_load = 0;
  endtask

  task automatic sweep();
    for (int v = 0; v < (1 << N); v++) begin
      step();
      in_vec = N'(v);
    end
    step();
    step();
  endtask

  function automatic void set_lit(ref logic [CW-1:0] c, input int t, input int i, input bit comp);
    c[t*2*N + 2*i + int'(comp)] = 1'b1;
  endfunction

  function automatic void set_or(ref logic [CW-1:0] c, input int o, input int t);
    c[AW + o*T + t] = 1'b1;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    // R1: reset state and unloaded array
    cur_req = "R1";
    repeat (3) step();
    rst = 0;
    sweep();

    // Config A: t0 = x0 & ~x1, t1 = x2, t2 empty, t3 = x3 & ~x3
    // out0 = t0|t1, out1 = t1|t3 (shared t1), out2 = t2
    c = '0;
    set_lit(c, 0, 0, 0); set_lit(c, 0, 1, 1);
    set_lit(c, 1, 2, 0);
    set_lit(c, 3, 3, 0); set_lit(c, 3, 3, 1);
    set_lit(c, 4, 0, 0); set_lit(c, 5, 1, 0);
    set_or(c, 0, 0); set_or(c, 0, 1);
    set_or(c, 1, 1); set_or(c, 1, 3);
    set_or(c, 2, 2);
    cur_req = "R2";
    load_cfg(c);
    cur_req = "R4_R5_R6_R7";
    sweep();

    // Config B: out2 has no term (R8), out0 = t3 alone (contradictory, R6)
    c = '0;
    set_lit(c, 0, 1, 0); set_lit(c, 0, 3, 1);
    set_lit(c, 3, 0, 0); set_lit(c, 3, 0, 1);
    set_or(c, 0, 3);
    set_or(c, 1, 0); set_or(c, 1, 2);
    cur_req = "R2";
    load_cfg(c);
    cur_req = "R8";
    sweep();

    // R3/R9: random configurations over all input vectors
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < CW; b++) c[b] = 1'($urandom);
      cur_req = "R2";
      load_cfg(c);
      cur_req = "R3_R9";
      sweep();
    end

    // R1: reset again mid-operation
    cur_req = "R1";
    step();
    rst = 1;
    repeat (2) step();
    rst = 0;
    sweep();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule